// File: doc/BRIEF.md
# Masked Half-Word GPIO Data Port

This block holds the data register of one GPIO bank and connects it to a 32-bit register bus. Software can change the pins in three ways. A plain write replaces every output pin at once. Two masked ports each carry a 16-bit keep-mask in the upper half of the word and new data in the lower half. One masked port covers the low sixteen pins and the other covers the pins from 16 upward. With these ports, firmware can flip chosen pins atomically without a read-modify-write. A read-only alias returns the current register contents.

Pins whose direction bit is 0 are inputs. Their levels pass through a two-flop synchronizer and are then stored in the register. Pins whose direction bit is 1 are outputs. An output pin is driven from its data bit only while its output-enable bit is also set. Whenever the register changes, the block presents the old and new values for one cycle, so that a neighbouring interrupt block can detect edges. The direction and enable settings arrive as ports from a configuration block.

The bank width is a parameter from 17 to 32 pins. The high masked port therefore spans `PINS-16` pins. Data and mask bits above that width are reserved, and so are data bits above `PINS` in a plain write.

Top module: `gpio_mhw_port`

## Requirements
- R1: While reset is high and in the cycle after it, `pin_out` is all zeros and `chg_valid` is 0. After reset the register reads as 0 when `pin_in` is held low.
- R2: A write to word 1 (full data) loads bits `PINS-1:0` of the write data into every output-direction pin. Write-data bits at or above `PINS` have no effect.
- R3: A write to word 2 (low masked) uses bits 31:16 as a keep-mask and bits 15:0 as data for pins 0–15. A mask bit of 1 keeps the pin's old value, and a mask bit of 0 loads the data bit.
- R4: A write to word 3 (high masked) applies the same rule to pins 16 to `PINS-1`. Data bit j and mask bit 16+j control pin 16+j. Bits with j at or above `PINS-16` are ignored.
- R5: A read of word 2 or word 3 returns 0 on `bus_rdata` in the cycle after `bus_rd`.
- R6: A read of word 0 (alias) or word 1 returns the register contents, zero-extended, in the cycle after `bus_rd`. A write to word 0 changes nothing.
- R7: `pin_out[i]` equals data bit i when `pin_dir[i]` and `pin_oe[i]` are both 1, and is 0 otherwise. It reflects a bus write from the clock edge that samples the write strobe onward.
- R8: For a pin with `pin_dir[i]`=0, the register bit follows `pin_in[i]` three clock edges after the input changes, and bus writes do not alter that bit.
- R9: When the register changes, `chg_valid` is 1 for exactly one cycle, with `chg_old` holding the previous value and `chg_new` the new one.
- R10: A write that leaves the register unchanged, including a write to the alias, does not raise `chg_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one 32-bit word |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 2 | Word select: 0 alias, 1 full data, 2 low masked, 3 high masked |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_dir | input | PINS | Direction per pin, 1 = output |
| pin_oe | input | PINS | Output enable per pin |
| pin_in | input | PINS | Asynchronous external input levels |
| pin_out | output | PINS | Registered output levels |
| chg_valid | output | 1 | One-cycle pulse on register change |
| chg_old | output | PINS | Register value before the change |
| chg_new | output | PINS | Register value after the change |

## Verification
The bench aims at the mask polarity in both masked ports. A design that inverts it would load the pins meant to be kept, and would leave the pins meant to be written unchanged. It sets bits above the high-port width and above the bank width in the write data. A design that ignores the bank width would corrupt neighbouring pins or touch bits that do not exist. It also checks that input-direction pins survive bus writes and follow the synchronized input after exactly three edges. A design that lets bus data through, or that adds or drops a synchronizer stage, would show the wrong bits or change in the wrong cycle. Finally, it writes to the alias and rewrites an unchanged value. A design that forgets the alias is read-only, or that pulses on every write, would raise a spurious change report.

// File: rtl/gpio_mhw_pkg.sv
package gpio_mhw_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    SEL_ALIAS = 2'd0,
    SEL_FULL  = 2'd1,
    SEL_LOW   = 2'd2,
    SEL_HIGH  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_mhw_sync.sv
module gpio_mhw_sync #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_mhw_merge.sv
module gpio_mhw_merge
  import gpio_mhw_pkg::*;
#(
  parameter int PINS = 26
) (
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [BUS_W-1:0] wdata,
  input  logic [PINS-1:0]  cur,
  output logic [PINS-1:0]  wr_val
);
  logic hit_full, hit_low, hit_high;
  assign hit_full = wr_en && (sel == SEL_FULL);
  assign hit_low  = wr_en && (sel == SEL_LOW);
  assign hit_high = wr_en && (sel == SEL_HIGH);

  for (genvar i = 0; i < PINS; i++) begin : g_bit
    if (i < HALF_W) begin : g_lo
      assign wr_val[i] = hit_full ? wdata[i] :
                         (hit_low && !wdata[HALF_W+i]) ? wdata[i] : cur[i];
    end else begin : g_hi
      localparam int J = i - HALF_W;
      assign wr_val[i] = hit_full ? wdata[i] :
                         (hit_high && !wdata[HALF_W+J]) ? wdata[J] : cur[i];
    end
  end
endmodule

// File: rtl/gpio_mhw_rdmux.sv
module gpio_mhw_rdmux
  import gpio_mhw_pkg::*;
#(
  parameter int PINS = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [PINS-1:0]  data,
  output logic [BUS_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (rd_en && (sel == SEL_ALIAS || sel == SEL_FULL))
        rdata[PINS-1:0] <= data;
    end
  end
endmodule

// File: rtl/gpio_mhw_port.sv
module gpio_mhw_port
  import gpio_mhw_pkg::*;
#(
  parameter int PINS = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_word,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [PINS-1:0]  pin_dir,
  input  logic [PINS-1:0]  pin_oe,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  pin_out,
  output logic             chg_valid,
  output logic [PINS-1:0]  chg_old,
  output logic [PINS-1:0]  chg_new
);
  reg_sel_e        sel;
  logic [PINS-1:0] data_q, data_d, wr_val, in_sync;

  assign sel = reg_sel_e'(bus_word);

  gpio_mhw_sync #(.W(PINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  gpio_mhw_merge #(.PINS(PINS)) u_merge (
    .wr_en  (bus_wr),
    .sel    (sel),
    .wdata  (bus_wdata),
    .cur    (data_q),
    .wr_val (wr_val)
  );

  gpio_mhw_rdmux #(.PINS(PINS)) u_rdmux (
    .clk   (clk),
    .rst   (rst),
    .rd_en (bus_rd),
    .sel   (sel),
    .data  (data_q),
    .rdata (bus_rdata)
  );

  // Output-direction pins take bus data; input-direction pins take the synchronized level.
  assign data_d = (pin_dir & wr_val) | (~pin_dir & in_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      pin_out   <= '0;
      chg_valid <= 1'b0;
      chg_old   <= '0;
      chg_new   <= '0;
    end else begin
      data_q    <= data_d;
      pin_out   <= data_d & pin_dir & pin_oe;
      chg_valid <= (data_d != data_q);
      if (data_d != data_q) begin
        chg_old <= data_q;
        chg_new <= data_d;
      end
    end
  end
endmodule

// File: rtl/gpio_mhw_chk.sv
module gpio_mhw_chk
  import gpio_mhw_pkg::*;
#(
  parameter int PINS = 26
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic [1:0]       bus_word,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [PINS-1:0]  pin_dir,
  input logic [PINS-1:0]  pin_oe,
  input logic [PINS-1:0]  pin_out,
  input logic             chg_valid,
  input logic [PINS-1:0]  chg_old,
  input logic [PINS-1:0]  chg_new,
  input logic [PINS-1:0]  data_q
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk)
    if (rst_d) p_quiet_after_reset_r1: assert (pin_out == '0 && !chg_valid);

  p_masked_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_word[1]) |=> (bus_rdata == '0));

  p_alias_matches_reg_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_word[1]) |=> (bus_rdata[PINS-1:0] == $past(data_q)));

  p_drive_only_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_out & ~($past(pin_dir) & $past(pin_oe))) == '0));

  p_change_differs_r9: assert property (@(posedge clk) disable iff (rst)
    chg_valid |-> (chg_old != chg_new));

  p_change_tracks_reg_r9: assert property (@(posedge clk) disable iff (rst)
    chg_valid |-> (chg_new == data_q));
endmodule

bind gpio_mhw_port gpio_mhw_chk #(.PINS(PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_word  (bus_word),
  .bus_rdata (bus_rdata),
  .pin_dir   (pin_dir),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .chg_valid (chg_valid),
  .chg_old   (chg_old),
  .chg_new   (chg_new),
  .data_q    (data_q)
);

// File: tb/gpio_mhw_port_tb.sv
module gpio_mhw_port_tb;
  localparam int PINS = 26;
  localparam int HI_W = PINS - 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]       bus_word = 2'd0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [PINS-1:0]  pin_dir = '0, pin_oe = '0, pin_in = '0;
  logic [PINS-1:0]  pin_out, chg_old, chg_new;
  logic             chg_valid;

  always #5 clk = ~clk;

  gpio_mhw_port #(.PINS(PINS)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_dir(pin_dir), .pin_oe(pin_oe),
    .pin_in(pin_in), .pin_out(pin_out), .chg_valid(chg_valid), .chg_old(chg_old),
    .chg_new(chg_new)
  );

  typedef struct {
    int          due;
    int          kind;  // 0 rdata, 1 pin_out, 2 chg_valid, 3 chg_old, 4 chg_new
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       q[$];
  int          cyc = 0;
  int          total = 0, bad = 0;
  logic [PINS-1:0] mdata = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items as their cycle comes due.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      case (it.kind)
        0: check(it.req, "rdata", bus_rdata, it.exp);
        1: check(it.req, "pin_out", 32'(pin_out), it.exp);
        2: check(it.req, "chg_valid", 32'(chg_valid), it.exp);
        3: check(it.req, "chg_old", 32'(chg_old), it.exp);
        default: check(it.req, "chg_new", 32'(chg_new), it.exp);
      endcase
    end
  end

  task automatic push(int due, int kind, logic [31:0] exp, string req);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic expect_update(int due, logic [PINS-1:0] old_v, string req);
    push(due, 1, 32'(mdata & pin_dir & pin_oe), req);
    push(due, 2, 32'(old_v != mdata), req);
    if (old_v != mdata) begin
      push(due, 3, 32'(old_v), req);
      push(due, 4, 32'(mdata), req);
    end
  endtask

  // Driver: one bus write, model update, expected items pushed.
  task automatic bus_write(logic [1:0] word, logic [31:0] wd, string req);
    logic [PINS-1:0] old_v;
    @(negedge clk);
    old_v = mdata;
    for (int i = 0; i < PINS; i++) begin
      if (pin_dir[i]) begin
        if (word == 2'd1) mdata[i] = wd[i];
        else if (word == 2'd2 && i < 16 && !wd[16+i]) mdata[i] = wd[i];
        else if (word == 2'd3 && i >= 16 && (i - 16) < HI_W && !wd[i]) mdata[i] = wd[i-16];
      end
    end
    bus_wr = 1'b1; bus_word = word; bus_wdata = wd;
    expect_update(cyc + 1, old_v, req);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    @(negedge clk);
  endtask

  task automatic bus_read(logic [1:0] word, logic [31:0] exp, string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_word = word;
    push(cyc + 1, 0, exp, req);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive_inputs(logic [PINS-1:0] v, string req);
    logic [PINS-1:0] old_v;
    @(negedge clk);
    old_v = mdata;
    pin_in = v;
    mdata = (mdata & pin_dir) | (v & ~pin_dir);
    push(cyc + 2, 2, 32'(0), req);  // nothing yet after two edges
    expect_update(cyc + 3, old_v, req);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pin_dir = 26'h00F_FFFF;          // pins 0..19 outputs, 20..25 inputs
    pin_oe  = ~(26'(1) << 3);        // pin 3 output disabled
    repeat (3) @(negedge clk);
    check("R1", "pin_out in reset", 32'(pin_out), 0);
    check("R1", "chg_valid in reset", 32'(chg_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "pin_out after reset", 32'(pin_out), 0);
    bus_read(2'd1, 32'h0, "R1");

    // R2: full write with reserved high bits set; R8: input pins unaffected
    bus_write(2'd1, 32'hFFFF_FFFF, "R2");
    bus_read(2'd1, 32'h000F_FFFF, "R2");
    bus_read(2'd0, 32'h000F_FFFF, "R6");

    // R3: low masked, keep pins 8..15, clear 0..7
    bus_write(2'd2, 32'hFF00_0000, "R3");
    bus_read(2'd0, 32'h000F_FF00, "R3");

    // R4: high masked, keep j0,j2, write others; bits above HI_W ignored
    bus_write(2'd3, 32'hFC05_FFF0, "R4");
    bus_read(2'd1, 32'h0005_FF00, "R4");

    // R5: masked ports read as zero
    bus_read(2'd2, 32'h0, "R5");
    bus_read(2'd3, 32'h0, "R5");

    // R6 / R10: alias write ignored, no change pulse
    bus_write(2'd0, 32'h0000_0000, "R10");
    bus_read(2'd0, 32'h0005_FF00, "R6");

    // R8: inputs reach register after three edges; output pins ignore pin_in
    drive_inputs('1, "R8");
    bus_read(2'd0, 32'h03F5_FF00, "R8");
    bus_write(2'd1, 32'h0000_0008, "R8");
    bus_read(2'd1, 32'h03F0_0008, "R8");

    // R7: pin 3 held low while disabled, driven one edge after enable
    @(negedge clk);
    check("R7", "pin_out disabled pin", 32'(pin_out), 0);
    pin_oe = '1;
    push(cyc + 1, 1, 32'h0000_0008, "R7");
    repeat (2) @(negedge clk);

    // R10: rewriting same value raises no change
    bus_write(2'd1, 32'h0000_0008, "R10");
    // R9: change pulse lasts one cycle only
    bus_write(2'd2, 32'h0000_0001, "R9");
    @(negedge clk);
    check("R9", "chg_valid drops", 32'(chg_valid), 0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule